// File: doc/BRIEF.md
# DRAM Clock-Enable Power-State Sequencer

This block sits on the controller side of a DDR2-style SDRAM and owns the clock-enable pin together with the idle commands that have to go with it. It moves the device between normal running, two kinds of power-down and self refresh. Two request inputs drive it: one for power-down and one for self refresh. Two status inputs qualify them: whether every bank is idle, and whether a read, write, mode-register load or precharge is still in progress. It answers with the clock-enable level, a two-bit command, the current power state, and two permission flags that the rest of the controller uses to gate its own traffic after a self-refresh exit.

The sequencer never lets a clock-enable transition go out with an illegal command. A falling edge carries NOP for power-down or REFRESH for self refresh. A rising edge carries NOP. While the pin stays low it issues DESELECT. Each level is held for a minimum number of cycles. Power-down cannot refresh the array, so the time spent there is capped. When the cap is reached the sequencer wakes the device and flags that a refresh is owed. A request that cannot be served yet is held off, never dropped, and never issued in a state where it would be illegal.

Top module: `cke_pwr_seq`

## Requirements
- R1: After reset, cke is 1, cmd is NOP, mode is RUN, cmd_ok and rd_ok are 1, and refresh_due is 0. The encodings are: cmd NOP=0, DESELECT=1, REFRESH=2; mode RUN=0, precharge power-down=1, active power-down=2, self refresh=3.
- R2: In RUN, a power-down request makes cke fall with cmd NOP at the next clock edge, provided entry is permitted. The new mode is 1 if banks_idle was high and 2 if it was low.
- R3: On every cycle that cke is low, other than the cycle of the falling edge itself, cmd is DESELECT.
- R4: In power-down, dropping pd_req makes cke rise with cmd NOP and mode RUN, once the dwell rule allows.
- R5: In RUN, a self-refresh request made while banks_idle is high makes cke fall with cmd REFRESH and mode 3. A self-refresh request takes priority over a power-down request in the same cycle.
- R6: While op_busy is high, no entry takes place, and a self-refresh request is not acted on while banks_idle is low. A request held through either condition is served at the first edge after the condition clears.
- R7: Every cke level, high or low, is held for at least MIN_DWELL cycles before it changes. A request that arrives sooner waits.
- R8: After PD_LIMIT cycles with cke low in power-down while pd_req stays high, cke rises with NOP and refresh_due goes to 1. refresh_due stays 1, and no new power-down entry is made, until pd_req is seen low; then it returns to 0 on the next edge.
- R9: Exiting self refresh (sr_req low) raises cke with NOP and drops cmd_ok for exactly XSNR_CYC cycles. No entry of any kind is made during that window.
- R10: After a self-refresh exit, rd_ok is 0 for exactly XSRD_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req | input | 1 | Request to enter or stay in power-down |
| sr_req | input | 1 | Request to enter or stay in self refresh |
| banks_idle | input | 1 | High when every bank is precharged |
| op_busy | input | 1 | Read, write, mode load or precharge still in progress |
| cke | output | 1 | Clock-enable level driven to the memory |
| cmd | output | 2 | Command issued with this cycle (0 NOP, 1 DESELECT, 2 REFRESH) |
| mode | output | 2 | Power state (0 run, 1 precharge PD, 2 active PD, 3 self refresh) |
| cmd_ok | output | 1 | Non-read commands permitted |
| rd_ok | output | 1 | Read commands permitted |
| refresh_due | output | 1 | Power-down was cut short by the dwell cap |

## Verification
Every output comes from a register that reads the inputs at one edge. An entry or exit therefore shows up one clock after the inputs that permit it, and the bench samples on the falling edge that follows that rising edge. Dwell counts, the power-down cap and the two post-exit windows are measured as numbers of consecutive falling-edge samples, starting at the sample where the transition first appears. They are compared with MIN_DWELL, PD_LIMIT, XSNR_CYC and XSRD_CYC. A sweep over all sixteen request and status combinations, applied from a settled run state, predicts the next-cycle mode, cke and cmd arithmetically. A passive monitor in the bench checks the run length and the paired command at every cke transition.

// File: rtl/cke_seq_pkg.sv
package cke_seq_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_DESEL = 2'd1,
    CMD_REF   = 2'd2
  } cmd_e;

  typedef enum logic [1:0] {
    MD_RUN = 2'd0,
    MD_PPD = 2'd1,
    MD_APD = 2'd2,
    MD_SR  = 2'd3
  } mode_e;
endpackage

// File: rtl/cke_dwell_ctr.sv
// Counts how long the present clock-enable level has been held.
module cke_dwell_ctr #(
  parameter int MIN_DWELL = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic toggle,
  output logic can_toggle
);
  localparam int DW = $clog2(MIN_DWELL + 1);

  logic [DW-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst || toggle)
      held_q <= DW'(1);
    else if (held_q < DW'(MIN_DWELL))
      held_q <= held_q + DW'(1);
  end

  assign can_toggle = (held_q >= DW'(MIN_DWELL));
endmodule

// File: rtl/cke_gap_tmr.sv
// Down-counter loaded on an exit event; done while zero.
module cke_gap_tmr #(
  parameter int SPAN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  localparam int TW = $clog2(SPAN + 1);

  logic [TW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)
      left_q <= '0;
    else if (load)
      left_q <= TW'(SPAN);
    else if (left_q != '0)
      left_q <= left_q - TW'(1);
  end

  assign done = (left_q == '0);
endmodule

// File: rtl/cke_pwr_fsm.sv
module cke_pwr_fsm
  import cke_seq_pkg::*;
#(
  parameter int PD_LIMIT = 64
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  pd_req,
  input  logic  sr_req,
  input  logic  banks_idle,
  input  logic  op_busy,
  input  logic  can_toggle,
  input  logic  gap_done,
  output logic  cke_q,
  output cmd_e  cmd_q,
  output mode_e mode_q,
  output logic  due_q,
  output logic  toggle,
  output logic  sr_exit
);
  localparam int PW = $clog2(PD_LIMIT + 1);

  logic [PW-1:0] pd_cnt_q;
  logic          pd_full;
  logic          forced;
  logic          cke_n;
  cmd_e          cmd_n;
  mode_e         mode_n;

  assign pd_full = (pd_cnt_q >= PW'(PD_LIMIT - 1));

  always_comb begin
    mode_n  = mode_q;
    cke_n   = cke_q;
    cmd_n   = CMD_NOP;
    forced  = 1'b0;
    sr_exit = 1'b0;
    unique case (mode_q)
      MD_RUN: begin
        if (can_toggle && !op_busy && gap_done) begin
          if (sr_req && banks_idle) begin
            mode_n = MD_SR;
            cke_n  = 1'b0;
            cmd_n  = CMD_REF;
          end else if (pd_req && !due_q) begin
            mode_n = banks_idle ? MD_PPD : MD_APD;
            cke_n  = 1'b0;
          end
        end
      end
      MD_PPD, MD_APD: begin
        cmd_n = CMD_DESEL;
        if (can_toggle && (!pd_req || pd_full)) begin
          mode_n = MD_RUN;
          cke_n  = 1'b1;
          cmd_n  = CMD_NOP;
          forced = pd_req;
        end
      end
      MD_SR: begin
        cmd_n = CMD_DESEL;
        if (can_toggle && !sr_req) begin
          mode_n  = MD_RUN;
          cke_n   = 1'b1;
          cmd_n   = CMD_NOP;
          sr_exit = 1'b1;
        end
      end
      default: mode_n = MD_RUN;
    endcase
  end

  assign toggle = (cke_n != cke_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MD_RUN;
      cke_q    <= 1'b1;
      cmd_q    <= CMD_NOP;
      due_q    <= 1'b0;
      pd_cnt_q <= '0;
    end else begin
      mode_q <= mode_n;
      cke_q  <= cke_n;
      cmd_q  <= cmd_n;
      if (forced)
        due_q <= 1'b1;
      else if (!pd_req)
        due_q <= 1'b0;
      if ((mode_q == MD_PPD || mode_q == MD_APD) && !pd_full)
        pd_cnt_q <= pd_cnt_q + PW'(1);
      else if (mode_q == MD_RUN || mode_q == MD_SR)
        pd_cnt_q <= '0;
    end
  end
endmodule

// File: rtl/cke_pwr_seq.sv
module cke_pwr_seq
  import cke_seq_pkg::*;
#(
  parameter int MIN_DWELL = 3,
  parameter int PD_LIMIT  = 7800,
  parameter int XSNR_CYC  = 20,
  parameter int XSRD_CYC  = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pd_req,
  input  logic       sr_req,
  input  logic       banks_idle,
  input  logic       op_busy,
  output logic       cke,
  output logic [1:0] cmd,
  output logic [1:0] mode,
  output logic       cmd_ok,
  output logic       rd_ok,
  output logic       refresh_due
);
  logic  can_toggle;
  logic  toggle;
  logic  sr_exit;
  logic  cke_q;
  logic  due_q;
  cmd_e  cmd_q;
  mode_e mode_q;

  cke_dwell_ctr #(.MIN_DWELL(MIN_DWELL)) u_dwell (
    .clk(clk), .rst(rst), .toggle(toggle), .can_toggle(can_toggle)
  );

  cke_gap_tmr #(.SPAN(XSNR_CYC)) u_gap_cmd (
    .clk(clk), .rst(rst), .load(sr_exit), .done(cmd_ok)
  );

  cke_gap_tmr #(.SPAN(XSRD_CYC)) u_gap_rd (
    .clk(clk), .rst(rst), .load(sr_exit), .done(rd_ok)
  );

  cke_pwr_fsm #(.PD_LIMIT(PD_LIMIT)) u_fsm (
    .clk(clk), .rst(rst), .pd_req(pd_req), .sr_req(sr_req),
    .banks_idle(banks_idle), .op_busy(op_busy), .can_toggle(can_toggle),
    .gap_done(cmd_ok), .cke_q(cke_q), .cmd_q(cmd_q), .mode_q(mode_q),
    .due_q(due_q), .toggle(toggle), .sr_exit(sr_exit)
  );

  assign cke         = cke_q;
  assign cmd         = cmd_q;
  assign mode        = mode_q;
  assign refresh_due = due_q;
endmodule

// File: rtl/cke_pwr_seq_chk.sv
module cke_pwr_seq_chk #(
  parameter int MIN_DWELL = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       banks_idle,
  input logic       op_busy,
  input logic       cke,
  input logic [1:0] cmd,
  input logic [1:0] mode,
  input logic       cmd_ok
);
  localparam int LW = $clog2(MIN_DWELL + 1);

  logic          prev_q;
  logic [LW-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      len_q  <= LW'(1);
    end else begin
      prev_q <= cke;
      if (cke != prev_q)
        len_q <= LW'(1);
      else if (len_q < LW'(MIN_DWELL))
        len_q <= len_q + LW'(1);
    end
  end

  a_r7_min_dwell: assert property (@(posedge clk) disable iff (rst)
    (cke != prev_q) |-> (len_q >= LW'(MIN_DWELL)));

  a_r4_rise_with_nop: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> (cmd == 2'd0));

  a_r3_low_hold_deselect: assert property (@(posedge clk) disable iff (rst)
    (!cke && !$past(cke)) |-> (cmd == 2'd1));

  a_r5_refresh_on_sr_entry: assert property (@(posedge clk) disable iff (rst)
    (cmd == 2'd2) |-> ($fell(cke) && mode == 2'd3 && $past(banks_idle)));

  a_r6_no_entry_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> !$past(op_busy));

  a_r9_no_entry_in_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> $past(cmd_ok));

  a_r2_pd_kind: assert property (@(posedge clk) disable iff (rst)
    ($fell(cke) && cmd == 2'd0) |-> (mode == ($past(banks_idle) ? 2'd1 : 2'd2)));
endmodule

bind cke_pwr_seq cke_pwr_seq_chk #(.MIN_DWELL(MIN_DWELL)) u_chk (
  .clk(clk), .rst(rst), .banks_idle(banks_idle), .op_busy(op_busy),
  .cke(cke), .cmd(cmd), .mode(mode), .cmd_ok(cmd_ok)
);

// File: tb/sim_cke_pwr_seq.sv
module sim_cke_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_DWELL  = 3;
  localparam int PD_LIMIT   = 8;
  localparam int XSNR_CYC   = 4;
  localparam int XSRD_CYC   = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pd_req = 1'b0, sr_req = 1'b0, banks_idle = 1'b1, op_busy = 1'b0;
  logic       cke, cmd_ok, rd_ok, refresh_due;
  logic [1:0] cmd, mode;

  int total = 0, bad = 0, mon_total = 0, mon_bad = 0, cycles = 0;
  logic       mon_prev = 1'b1;
  int         mon_len = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  cke_pwr_seq #(.MIN_DWELL(MIN_DWELL), .PD_LIMIT(PD_LIMIT),
                .XSNR_CYC(XSNR_CYC), .XSRD_CYC(XSRD_CYC)) u0 (
    .clk(clk), .rst(rst), .pd_req(pd_req), .sr_req(sr_req),
    .banks_idle(banks_idle), .op_busy(op_busy), .cke(cke), .cmd(cmd),
    .mode(mode), .cmd_ok(cmd_ok), .rd_ok(rd_ok), .refresh_due(refresh_due)
  );

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      $display("FAIL watchdog: actual=hung expected=done");
      bad = bad + 1;
      summary();
    end
  end

  // Passive transition monitor (R7 run length, R2/R4/R5 paired command).
  always @(negedge clk) begin
    if (rst) begin
      mon_prev <= 1'b1;
      mon_len  <= 1;
    end else begin
      if (cke != mon_prev) begin
        mon_total <= mon_total + 2;
        if (mon_len < MIN_DWELL) begin
          mon_bad <= mon_bad + 1;
          $display("FAIL R7 level run: actual=%0d expected>=%0d", mon_len, MIN_DWELL);
        end
        if (cke ? (cmd != 2'd0) : (cmd == 2'd1)) begin
          mon_bad <= mon_bad + 1;
          $display("FAIL R4/R5 edge command: actual=%0d cke=%0d", cmd, cke);
        end
        mon_len <= 1;
      end else begin
        mon_len <= mon_len + 1;
      end
      mon_prev <= cke;
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_high();
    for (int i = 0; i < 60 && cke == 1'b0; i++) step();
  endtask

  task automatic settle();
    wait_high();
    repeat (XSRD_CYC + 4) step();
  endtask

  initial begin
    int n;
    int nok;
    int nrd;
    int leak;
    repeat (3) step();
    check("R1 cke", cke, 1);
    check("R1 cmd", cmd, 0);
    check("R1 mode", mode, 0);
    check("R1 cmd_ok", cmd_ok, 1);
    check("R1 rd_ok", rd_ok, 1);
    check("R1 refresh_due", refresh_due, 0);
    rst = 1'b0;
    repeat (5) step();

    // R2 precharge power-down entry, R3 deselect hold, R4/R7 exit after dwell
    pd_req = 1'b1; banks_idle = 1'b1;
    step();
    check("R2 ppd cke", cke, 0);
    check("R2 ppd cmd", cmd, 0);
    check("R2 ppd mode", mode, 1);
    pd_req = 1'b0;
    n = 1;
    for (int i = 0; i < 20 && cke == 1'b0; i++) begin
      step();
      if (cke == 1'b0) begin
        n++;
        check("R3 deselect", cmd, 1);
      end
    end
    check("R7 low dwell", n, MIN_DWELL);
    check("R4 exit cmd", cmd, 0);
    check("R4 exit mode", mode, 0);

    // R7 high dwell, R2 active power-down, R8 forced exit
    pd_req = 1'b1; banks_idle = 1'b0;
    n = 1;
    for (int i = 0; i < 20 && cke == 1'b1; i++) begin
      step();
      if (cke == 1'b1) n++;
    end
    check("R7 high dwell", n, MIN_DWELL);
    check("R2 apd mode", mode, 2);
    n = 1;
    for (int i = 0; i < 40 && cke == 1'b0; i++) begin
      step();
      if (cke == 1'b0) n++;
    end
    check("R8 cap length", n, PD_LIMIT);
    check("R8 due set", refresh_due, 1);
    check("R8 exit mode", mode, 0);
    repeat (10) step();
    check("R8 no reentry", cke, 1);
    check("R8 due held", refresh_due, 1);
    pd_req = 1'b0;
    step();
    check("R8 due clear", refresh_due, 0);

    // R6 busy hold-off
    banks_idle = 1'b1; op_busy = 1'b1; pd_req = 1'b1;
    repeat (6) step();
    check("R6 busy blocks", cke, 1);
    op_busy = 1'b0;
    step();
    check("R6 served cke", cke, 0);
    check("R6 served mode", mode, 1);
    pd_req = 1'b0;
    settle();

    // R6 self refresh held while banks active, then R5 entry
    sr_req = 1'b1; banks_idle = 1'b0;
    repeat (6) step();
    check("R6 sr blocked", cke, 1);
    banks_idle = 1'b1;
    step();
    check("R5 sr cke", cke, 0);
    check("R5 sr cmd", cmd, 2);
    check("R5 sr mode", mode, 3);
    repeat (5) begin
      step();
      check("R3 sr deselect", cmd, 1);
    end
    sr_req = 1'b0;
    step();
    check("R9 exit cke", cke, 1);
    check("R9 exit cmd", cmd, 0);
    check("R9 gap start", cmd_ok, 0);
    check("R10 gap start", rd_ok, 0);
    pd_req = 1'b1;
    nok = 1; nrd = 1; leak = 0;
    for (int i = 0; i < XSRD_CYC + 4; i++) begin
      step();
      if (!cmd_ok) nok++;
      if (!rd_ok) nrd++;
      if (!cmd_ok && !cke) leak++;
      if (!cke) pd_req = 1'b0;
    end
    check("R9 gap length", nok, XSNR_CYC);
    check("R9 no entry in gap", leak, 0);
    check("R10 read gap length", nrd, XSRD_CYC);
    settle();

    // R5 priority over power-down
    pd_req = 1'b1; sr_req = 1'b1; banks_idle = 1'b1;
    step();
    check("R5 priority mode", mode, 3);
    pd_req = 1'b0; sr_req = 1'b0;
    settle();

    // Sweep of every request/status combination from a settled run state
    for (int v = 0; v < 16; v++) begin
      int em;
      pd_req = v[0]; sr_req = v[1]; banks_idle = v[2]; op_busy = v[3];
      em = v[3] ? 0 : (v[1] && v[2]) ? 3 : v[0] ? (v[2] ? 1 : 2) : 0;
      step();
      check("R2/R5/R6 sweep mode", mode, em);
      check("R2/R5/R6 sweep cke", cke, (em == 0) ? 1 : 0);
      check("R2/R5 sweep cmd", cmd, (em == 3) ? 2 : 0);
      pd_req = 1'b0; sr_req = 1'b0; op_busy = 1'b0;
      settle();
    end

    step();
    summary();
  end
endmodule